// File: doc/BRIEF.md
# Comparator Trip Protection with Qualified One-Shot Latch

This block guards a pair of PWM outputs against fault conditions that analog comparators detect. Each of the two comparator levels first goes through a per-source polarity select, so an active-low fault can be treated as true. It then goes either through a digital stability filter or around it. Any enabled source that reports a fault sets a single sticky trip latch. While the latch is set, each PWM output is replaced by a level chosen for that output.

The latch holds after the fault goes away. Software releases it with a one-cycle clear strobe. If a clear and a fresh fault land in the same clock, the fault takes priority. A per-source status vector records which comparators caused or joined the trip.

Each filter is a two-state machine, FLT_LOW and FLT_HIGH, with a run counter. A move to the other state needs the opposite input level for QUAL_LEN consecutive clocks; the counter returns to zero whenever the input matches the current state. The trip latch is a two-state machine:
- ARMED goes to TRIPPED on any enabled event (transition ARM_TO_TRIP).
- TRIPPED goes back to ARMED on a clear strobe when no enabled event is present (transition TRIP_TO_ARM).
- Every other case keeps the current state (HOLD).

Top module: `tripq_protect`

## Requirements
- R1: A source's event level is its comparator input XOR its `cfg_inv` bit.
- R2: With `cfg_qual_en` bit set, a change of a source's event level is accepted only after the new level has been present at 3 consecutive rising clock edges. The trip latch reacts on the edge that follows. Shorter pulses have no effect.
- R3: With `cfg_qual_en` bit clear, the event level bypasses the filter and sets the latch on the first rising edge at which it is high.
- R4: A source whose `cfg_trip_en` bit is 0 never sets the latch or its status bit.
- R5: Once set, `trip_active` stays 1 after every fault input returns inactive, until a clear strobe.
- R6: `trip_clr` high at an edge with no enabled event present clears `trip_active` and all of `trip_src` at that edge.
- R7: `trip_clr` together with an enabled event at the same edge leaves `trip_active` at 1 and loads `trip_src` with exactly the sources active at that edge.
- R8: While tripped, each output follows its 2-bit force code. 00 passes the PWM input. 01 drives 1. 10 drives 0. 11 drives 0 and raises that output's `_hiz` flag.
- R9: While not tripped, each output equals its PWM input and its `_hiz` flag is 0.
- R10: `trip_src` bit i (bit 0 = comparator 0) is set when source i has an enabled event. Bits accumulate while tripped.
- R11: During and after reset the latch is ARMED, `trip_src` is 0, and both filters hold level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 2 | Comparator levels, bit i = source i |
| cfg_inv | input | 2 | Per-source polarity invert |
| cfg_qual_en | input | 2 | 1 = use stability filter, 0 = bypass |
| cfg_trip_en | input | 2 | Per-source trip enable |
| cfg_force_a | input | 2 | Force code for output A |
| cfg_force_b | input | 2 | Force code for output B |
| trip_clr | input | 1 | Clear strobe for the trip latch |
| pwm_a_in | input | 1 | Normal PWM A |
| pwm_b_in | input | 1 | Normal PWM B |
| pwm_a_out | output | 1 | Protected PWM A |
| pwm_b_out | output | 1 | Protected PWM B |
| pwm_a_hiz | output | 1 | Output A requested high impedance |
| pwm_b_hiz | output | 1 | Output B requested high impedance |
| trip_active | output | 1 | Trip latch state |
| trip_src | output | 2 | Sticky per-source trip status |

## Verification
The hardest case to reach from the ports is a clear strobe that lands on exactly the edge where an enabled event is live. With the filter on, that event becomes visible only three edges after the raw input moves. The directed part reaches it with the bypass path, which makes the event and the clear line up in one known cycle. The random part holds comparator levels for several cycles at a time and pulses the clear often, so filtered events also meet clears. A cycle-level model in the bench predicts every output on every cycle.

// File: rtl/tripq_pkg.sv
package tripq_pkg;
    typedef enum logic [1:0] {
        FRC_NONE = 2'b00,
        FRC_HIGH = 2'b01,
        FRC_LOW  = 2'b10,
        FRC_HIZ  = 2'b11
    } force_e;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_TRIPPED = 1'b1
    } trip_st_e;

    typedef enum logic {
        FLT_LOW  = 1'b0,
        FLT_HIGH = 1'b1
    } flt_st_e;
endpackage

// File: rtl/tripq_qual_filter.sv
module tripq_qual_filter
    import tripq_pkg::*;
#(
    parameter int QUAL_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic qout
);
    localparam int CW = (QUAL_LEN > 2) ? $clog2(QUAL_LEN) : 1;
    localparam logic [CW-1:0] LIM = CW'(QUAL_LEN - 1);

    flt_st_e        st, st_nxt;
    logic [CW-1:0]  cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= FLT_LOW;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = '0;
        unique case (st)
            FLT_LOW: begin
                if (din) begin
                    if (cnt == LIM) st_nxt = FLT_HIGH;
                    else            cnt_nxt = cnt + 1'b1;
                end
            end
            FLT_HIGH: begin
                if (!din) begin
                    if (cnt == LIM) st_nxt = FLT_LOW;
                    else            cnt_nxt = cnt + 1'b1;
                end
            end
            default: st_nxt = FLT_LOW;
        endcase
    end

    always_comb begin
        qout = (st == FLT_HIGH);
    end
endmodule

// File: rtl/tripq_latch.sv
module tripq_latch
    import tripq_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hit,
    input  logic             clr,
    output logic             active,
    output logic [N_SRC-1:0] src
);
    trip_st_e         st, st_nxt;
    logic [N_SRC-1:0] src_q, src_nxt;
    logic             any_hit;

    always_comb any_hit = |hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_ARMED;
            src_q <= '0;
        end else begin
            st    <= st_nxt;
            src_q <= src_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        src_nxt = src_q;
        unique case (st)
            ST_ARMED: begin
                if (any_hit) begin
                    st_nxt  = ST_TRIPPED;
                    src_nxt = hit;
                end
            end
            ST_TRIPPED: begin
                if (clr && !any_hit) begin
                    st_nxt  = ST_ARMED;
                    src_nxt = '0;
                end else if (clr) begin
                    src_nxt = hit;
                end else begin
                    src_nxt = src_q | hit;
                end
            end
            default: begin
                st_nxt  = ST_ARMED;
                src_nxt = '0;
            end
        endcase
    end

    always_comb begin
        active = (st == ST_TRIPPED);
        src    = src_q;
    end
endmodule

// File: rtl/tripq_out_mux.sv
module tripq_out_mux
    import tripq_pkg::*;
(
    input  logic       pwm_in,
    input  logic       active,
    input  logic [1:0] force_sel,
    output logic       out,
    output logic       hiz
);
    force_e fsel;

    always_comb begin
        fsel = force_e'(force_sel);
        out  = pwm_in;
        hiz  = 1'b0;
        if (active) begin
            unique case (fsel)
                FRC_NONE: out = pwm_in;
                FRC_HIGH: out = 1'b1;
                FRC_LOW:  out = 1'b0;
                FRC_HIZ: begin
                    out = 1'b0;
                    hiz = 1'b1;
                end
                default:  out = pwm_in;
            endcase
        end
    end
endmodule

// File: rtl/tripq_protect.sv
module tripq_protect
    import tripq_pkg::*;
#(
    parameter int N_SRC    = 2,
    parameter int QUAL_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] cmp_raw,
    input  logic [N_SRC-1:0] cfg_inv,
    input  logic [N_SRC-1:0] cfg_qual_en,
    input  logic [N_SRC-1:0] cfg_trip_en,
    input  logic [1:0]       cfg_force_a,
    input  logic [1:0]       cfg_force_b,
    input  logic             trip_clr,
    input  logic             pwm_a_in,
    input  logic             pwm_b_in,
    output logic             pwm_a_out,
    output logic             pwm_b_out,
    output logic             pwm_a_hiz,
    output logic             pwm_b_hiz,
    output logic             trip_active,
    output logic [N_SRC-1:0] trip_src
);
    localparam int N_OUT = 2;

    logic [N_SRC-1:0] cmp_lvl;
    logic [N_SRC-1:0] cmp_qual;
    logic [N_SRC-1:0] cmp_evt;
    logic [N_SRC-1:0] src_hit;

    logic [N_OUT-1:0] pin_in, pin_out, pin_hiz;
    logic [1:0]       pin_frc [N_OUT];

    always_comb cmp_lvl = cmp_raw ^ cfg_inv;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        tripq_qual_filter #(.QUAL_LEN(QUAL_LEN)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cmp_lvl[i]),
            .qout (cmp_qual[i])
        );
        always_comb cmp_evt[i] = cfg_qual_en[i] ? cmp_qual[i] : cmp_lvl[i];
    end

    always_comb src_hit = cmp_evt & cfg_trip_en;

    tripq_latch #(.N_SRC(N_SRC)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (src_hit),
        .clr   (trip_clr),
        .active(trip_active),
        .src   (trip_src)
    );

    always_comb begin
        pin_in     = {pwm_b_in, pwm_a_in};
        pin_frc[0] = cfg_force_a;
        pin_frc[1] = cfg_force_b;
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        tripq_out_mux u_mux (
            .pwm_in   (pin_in[k]),
            .active   (trip_active),
            .force_sel(pin_frc[k]),
            .out      (pin_out[k]),
            .hiz      (pin_hiz[k])
        );
    end

    always_comb begin
        pwm_a_out = pin_out[0];
        pwm_b_out = pin_out[1];
        pwm_a_hiz = pin_hiz[0];
        pwm_b_hiz = pin_hiz[1];
    end
endmodule

// File: rtl/tripq_protect_chk.sv
module tripq_protect_chk #(
    parameter int N_SRC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trip_clr,
    input logic [N_SRC-1:0] hit,
    input logic [N_SRC-1:0] xlvl,
    input logic [N_SRC-1:0] qlvl,
    input logic             trip_active,
    input logic [N_SRC-1:0] trip_src,
    input logic [1:0]       cfg_force_a,
    input logic             pwm_a_in,
    input logic             pwm_b_in,
    input logic             pwm_a_out,
    input logic             pwm_b_out,
    input logic             pwm_a_hiz,
    input logic             pwm_b_hiz
);
    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_active && !trip_clr) |=> trip_active); // R5

    AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_clr && hit == '0) |=> (!trip_active && trip_src == '0)); // R6

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> trip_active); // R7

    AST_CLEAR_RELOAD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_clr && (|hit)) |=> (trip_src == $past(hit))); // R7

    AST_SRC_TRACKS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        trip_active == (trip_src != '0)); // R10

    AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_active |-> (pwm_a_out == pwm_a_in && pwm_b_out == pwm_b_in
                          && !pwm_a_hiz && !pwm_b_hiz)); // R9

    AST_FORCE_LOW_A: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_active && cfg_force_a == 2'b10) |-> (!pwm_a_out && !pwm_a_hiz)); // R8

    for (genvar i = 0; i < N_SRC; i++) begin : g_q
        AST_QUAL_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(qlvl[i]) |-> $past(xlvl[i])); // R2
        AST_QUAL_FALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(qlvl[i]) |-> !$past(xlvl[i])); // R2
    end
endmodule

bind tripq_protect tripq_protect_chk #(.N_SRC(N_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_clr   (trip_clr),
    .hit        (src_hit),
    .xlvl       (cmp_lvl),
    .qlvl       (cmp_qual),
    .trip_active(trip_active),
    .trip_src   (trip_src),
    .cfg_force_a(cfg_force_a),
    .pwm_a_in   (pwm_a_in),
    .pwm_b_in   (pwm_b_in),
    .pwm_a_out  (pwm_a_out),
    .pwm_b_out  (pwm_b_out),
    .pwm_a_hiz  (pwm_a_hiz),
    .pwm_b_hiz  (pwm_b_hiz)
);

// File: tb/sim_tripq_protect.sv
`timescale 1ns/1ps
module sim_tripq_protect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_raw = '0, cfg_inv = '0, cfg_qual_en = '0, cfg_trip_en = '0;
    logic [1:0] cfg_force_a = '0, cfg_force_b = '0;
    logic       trip_clr = 1'b0, pwm_a_in = 1'b0, pwm_b_in = 1'b0;
    logic       pwm_a_out, pwm_b_out, pwm_a_hiz, pwm_b_hiz, trip_active;
    logic [1:0] trip_src;

    int total = 0;
    int bad = 0;

    // bench model state
    logic [1:0] m_q;
    int         m_run [2];
    logic       m_trip;
    logic [1:0] m_src;

    always #2.5 clk = ~clk;

    tripq_protect u0 (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .cfg_inv(cfg_inv),
        .cfg_qual_en(cfg_qual_en), .cfg_trip_en(cfg_trip_en),
        .cfg_force_a(cfg_force_a), .cfg_force_b(cfg_force_b),
        .trip_clr(trip_clr), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out),
        .pwm_a_hiz(pwm_a_hiz), .pwm_b_hiz(pwm_b_hiz),
        .trip_active(trip_active), .trip_src(trip_src)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_out(input logic pin, input logic [1:0] frc);
        if (!m_trip) return pin;
        case (frc)
            2'b01:   return 1'b1;
            2'b10:   return 1'b0;
            2'b11:   return 1'b0;
            default: return pin;
        endcase
    endfunction

    function automatic logic exp_hiz(input logic [1:0] frc);
        return m_trip && (frc == 2'b11);
    endfunction

    task automatic model_reset();
        m_q = '0; m_run[0] = 0; m_run[1] = 0; m_trip = 1'b0; m_src = '0;
    endtask

    task automatic model_edge();
        logic [1:0] x, ev, hit;
        x  = cmp_raw ^ cfg_inv;                         // R1
        ev = (cfg_qual_en & m_q) | (~cfg_qual_en & x);  // R2 R3
        hit = ev & cfg_trip_en;                         // R4
        for (int i = 0; i < 2; i++) begin
            if (x[i] != m_q[i]) begin
                if (m_run[i] == 2) begin m_q[i] = x[i]; m_run[i] = 0; end
                else m_run[i]++;
            end else m_run[i] = 0;
        end
        if (hit != 0) begin
            m_src  = (m_trip && !trip_clr) ? (m_src | hit) : hit;
            m_trip = 1'b1;
        end else if (trip_clr) begin
            m_trip = 1'b0; m_src = '0;
        end
    endtask

    task automatic compare(input string tag);
        chk(trip_active == m_trip, tag, trip_active, m_trip);
        chk(trip_src == m_src, "R10", trip_src, m_src);
        chk(pwm_a_out == exp_out(pwm_a_in, cfg_force_a), m_trip ? "R8" : "R9",
            pwm_a_out, exp_out(pwm_a_in, cfg_force_a));
        chk(pwm_b_out == exp_out(pwm_b_in, cfg_force_b), m_trip ? "R8" : "R9",
            pwm_b_out, exp_out(pwm_b_in, cfg_force_b));
        chk(pwm_a_hiz == exp_hiz(cfg_force_a), m_trip ? "R8" : "R9",
            pwm_a_hiz, exp_hiz(cfg_force_a));
        chk(pwm_b_hiz == exp_hiz(cfg_force_b), m_trip ? "R8" : "R9",
            pwm_b_hiz, exp_hiz(cfg_force_b));
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        model_reset();
        pwm_a_in = 1'b1; pwm_b_in = 1'b0;
        cmp_raw = 2'b11; cfg_trip_en = 2'b11; cfg_qual_en = 2'b00;
        cfg_force_a = 2'b10; cfg_force_b = 2'b01;
        repeat (3) @(negedge clk);
        // R11: reset state while inputs are active
        chk(trip_active == 1'b0, "R11", trip_active, 0);
        chk(trip_src == 2'b00, "R11", trip_src, 0);
        chk(pwm_a_out == 1'b1 && pwm_b_out == 1'b0, "R11", {pwm_b_out, pwm_a_out}, 1);
        cmp_raw = 2'b00; cfg_qual_en = 2'b11;
        rst_n = 1'b1;
        step("R11");

        // R2: two-cycle glitch is filtered out
        cmp_raw = 2'b01; step("R2"); step("R2");
        cmp_raw = 2'b00; step("R2"); step("R2"); step("R2");
        chk(trip_active == 1'b0, "R2", trip_active, 0);
        // R2: held three edges -> latch on the fourth
        cmp_raw = 2'b01; step("R2"); step("R2"); step("R2");
        chk(trip_active == 1'b0, "R2", trip_active, 0);
        step("R2");
        chk(trip_active == 1'b1, "R2", trip_active, 1);
        chk(pwm_a_out == 1'b0, "R8", pwm_a_out, 0);
        chk(pwm_b_out == 1'b1, "R8", pwm_b_out, 1);
        chk(trip_src == 2'b01, "R10", trip_src, 1);

        // R5: stays set after the fault ends
        cmp_raw = 2'b00;
        repeat (5) step("R5");
        chk(trip_active == 1'b1, "R5", trip_active, 1);
        // R6: clear with no event
        trip_clr = 1'b1; step("R6"); trip_clr = 1'b0;
        chk(trip_active == 1'b0, "R6", trip_active, 0);
        chk(trip_src == 2'b00, "R6", trip_src, 0);

        // R1 + R3: inverted source 1 on the bypass path trips in one edge
        cfg_inv = 2'b10; cfg_qual_en = 2'b01; cmp_raw = 2'b00;
        step("R3");
        chk(trip_active == 1'b1, "R3", trip_active, 1);
        chk(trip_src == 2'b10, "R1", trip_src, 2);
        cmp_raw = 2'b10; step("R5");
        // R7: clear and live event on the same edge
        cmp_raw = 2'b00; trip_clr = 1'b1; step("R7");
        chk(trip_active == 1'b1, "R7", trip_active, 1);
        chk(trip_src == 2'b10, "R7", trip_src, 2);
        cmp_raw = 2'b10; step("R6"); trip_clr = 1'b0;
        chk(trip_active == 1'b0, "R6", trip_active, 0);

        // R4: disabled source is ignored
        cfg_inv = 2'b00; cfg_qual_en = 2'b00; cfg_trip_en = 2'b01; cmp_raw = 2'b10;
        repeat (4) step("R4");
        chk(trip_active == 1'b0, "R4", trip_active, 0);
        chk(trip_src == 2'b00, "R4", trip_src, 0);

        // R8: high-impedance code and pass-through code while tripped
        cfg_force_a = 2'b11; cfg_force_b = 2'b00; pwm_b_in = 1'b1;
        cmp_raw = 2'b01; step("R8");
        chk(pwm_a_hiz == 1'b1 && pwm_a_out == 1'b0, "R8", {pwm_a_hiz, pwm_a_out}, 2);
        chk(pwm_b_out == 1'b1 && pwm_b_hiz == 1'b0, "R8", {pwm_b_hiz, pwm_b_out}, 1);
        cmp_raw = 2'b00; trip_clr = 1'b1; step("R6"); trip_clr = 1'b0;
        cfg_trip_en = 2'b11;

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if (n % 64 == 0) begin
                cfg_inv     = 2'($urandom);
                cfg_qual_en = 2'($urandom);
                cfg_trip_en = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
                cfg_force_a = 2'($urandom);
                cfg_force_b = 2'($urandom);
            end
            for (int i = 0; i < 2; i++)
                if ($urandom % 5 == 0) cmp_raw[i] = ~cmp_raw[i];
            trip_clr = ($urandom % 12 == 0);
            pwm_a_in = 1'($urandom);
            pwm_b_in = 1'($urandom);
            step("R7");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule